// File: doc/BRIEF.md
# Divider Ratio Search Engine

This block works out how to reach a requested clock rate from one of four candidate source clocks through a two-stage divider. The first stage is a coarse pre-divider that only the last source (index 3) actually uses. The second stage is a small post-divider. For each source the engine derives the overall division ratio needed to land at or below the request. It then splits that ratio across the two stages and computes the rate that would really come out.

Of the four candidates, it keeps the one whose resulting rate is the highest that does not exceed the request. It reports that source's index, the two divider codes and the resulting rate. An error flag is raised when no candidate can meet the request.

A caller places the four rates and the target on the inputs and pulses `start`. The engine captures them and evaluates the sources one after another, using a single shared 32-step restoring divider twice per source. It then pulses `done` for one cycle. The results stay valid from that pulse until the next accepted start.

Top module: `ratio_search`

## Requirements
- R1: After reset, `done`, `err`, `sel_src`, `pre_code`, `post_code` and `achieved` are all zero.
- R2: For each usable source, the working target is the request clamped to the source rate when the request is larger. The total ratio is the source rate divided by the working target, rounded up.
- R3: For sources 0 to 2, and for source 3 when the total ratio is at most 4, the pre ratio is 1 (`pre_code` 0). The post ratio is the total ratio, saturated at 4, and `post_code` is the post ratio minus one.
- R4: For source 3 with a total ratio from 5 to 31, the pre ratio equals the total ratio and the post ratio is 1. `pre_code` is the pre ratio minus one.
- R5: For source 3, the post ratio and pre ratio follow the total ratio in three bands:
  - total ratio 32 to 63: post ratio 2, pre ratio ceil(total/2);
  - total ratio 64 to 95: post ratio 3, pre ratio ceil(total/3);
  - total ratio 96 and above: post ratio 4, pre ratio ceil(total/4) saturated at 32.
- R6: A source's achieved rate is floor(floor(rate / pre ratio) / post ratio).
- R7: The reported source is the one with the largest achieved rate that is not above the request. On equal achieved rates, the lowest index wins.
- R8: A source rate of zero is skipped. When no source qualifies, or the request is zero, `err` is 1 and `sel_src`, `pre_code`, `post_code` and `achieved` are 0.
- R9: `done` is high for exactly one cycle per accepted start. A `start` that arrives while a search is running is ignored, and so are input changes during a search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a search with the present inputs (ignored while busy) |
| src_rates | input | 128 | Four source rates; source i occupies bits [32*i+31:32*i] |
| target | input | 32 | Requested output rate |
| done | output | 1 | One-cycle pulse when the search is complete |
| sel_src | output | 2 | Index of the chosen source |
| pre_code | output | 5 | Pre ratio minus one |
| post_code | output | 2 | Post ratio minus one |
| achieved | output | 32 | Rate produced by the chosen settings |
| err | output | 1 | No source can meet the request |

## Verification
The assertions assume that `start` is a single-cycle pulse while the engine is idle. They also assume that reset is held long enough for the internal synchronizer to clear.

The stimulus drives each start for one cycle only and then waits for `done`. One case deliberately pulses `start` again mid-search, with different inputs, to show that the pulse is ignored. Rates and targets are chosen so that every band boundary of source 3 is reached, along with clamping, saturation, ties, zero rates and a zero target.

// File: rtl/ratio_search_pkg.sv
package ratio_search_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_TOT,
    S_SPLIT,
    S_ACH,
    S_FIN
  } srch_state_t;
endpackage

// File: rtl/rs_divider.sv
// Restoring divider: one quotient bit per cycle, done pulses after W steps.
module rs_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W);

  logic [W-1:0] q_r, q_n, r_r, r_n, d_r, d_n, n_r, n_n;
  logic [CW-1:0] cnt_r, cnt_n;
  logic         busy_r, busy_n, done_r, done_n;
  logic [W:0]   shifted, diff;
  logic         fits;

  assign shifted = {r_r, q_r[W-1]};
  assign diff    = shifted - {1'b0, d_r};
  assign fits    = shifted >= {1'b0, d_r};

  always_comb begin
    q_n = q_r; r_n = r_r; d_n = d_r; n_n = n_r;
    cnt_n = cnt_r; busy_n = busy_r; done_n = 1'b0;
    if (go) begin
      q_n = num; r_n = '0; d_n = den; n_n = num;
      cnt_n = '0; busy_n = 1'b1;
    end else if (busy_r) begin
      q_n   = {q_r[W-2:0], fits};
      r_n   = fits ? diff[W-1:0] : shifted[W-1:0];
      cnt_n = cnt_r + CW'(1);
      if (cnt_r == CW'(W-1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0; r_r <= '0; d_r <= '0; n_r <= '0;
      cnt_r <= '0; busy_r <= 1'b0; done_r <= 1'b0;
    end else begin
      q_r <= q_n; r_r <= r_n; d_r <= d_n; n_r <= n_n;
      cnt_r <= cnt_n; busy_r <= busy_n; done_r <= done_n;
    end
  end

  assign done = done_r;
  assign quo  = q_r;
  assign rem  = r_r;

  // R2: the quotient and remainder reproduce the captured dividend exactly
  p_div_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (({{W{1'b0}}, q_r} * {{W{1'b0}}, d_r} + {{W{1'b0}}, r_r}) == {{W{1'b0}}, n_r})
             && (r_r < d_r));
endmodule

// File: rtl/rs_ratio_split.sv
// Splits a total ratio into pre and post ratios (banded only for one source).
module rs_ratio_split #(
  parameter int W        = 32,
  parameter int PRE_MAX  = 32,
  parameter int POST_MAX = 4
) (
  input  logic [W-1:0]                   total,
  input  logic                           banded,
  output logic [$clog2(PRE_MAX):0]       pre_ratio,
  output logic [$clog2(POST_MAX):0]      post_ratio
);
  localparam int PRW = $clog2(PRE_MAX) + 1;
  localparam int POW = $clog2(POST_MAX) + 1;

  logic [7:0]   low8;
  logic [7:0]   half_up, third_up;
  logic [W-1:0] quarter_up;

  assign low8       = total[7:0];
  assign half_up    = (low8 + 8'd1) >> 1;
  assign third_up   = (low8 + 8'd2) / 8'd3;
  assign quarter_up = (total >> 2) + W'(|total[1:0]);

  always_comb begin
    pre_ratio  = PRW'(1);
    post_ratio = POW'(1);
    if (!banded || total <= W'(POST_MAX)) begin
      post_ratio = (total > W'(POST_MAX)) ? POW'(POST_MAX) : total[POW-1:0];
    end else if (total < W'(PRE_MAX)) begin
      pre_ratio = total[PRW-1:0];
    end else if (total < W'(2*PRE_MAX)) begin
      post_ratio = POW'(2);
      pre_ratio  = half_up[PRW-1:0];
    end else if (total < W'(3*PRE_MAX)) begin
      post_ratio = POW'(3);
      pre_ratio  = third_up[PRW-1:0];
    end else begin
      post_ratio = POW'(POST_MAX);
      pre_ratio  = (quarter_up > W'(PRE_MAX)) ? PRW'(PRE_MAX) : quarter_up[PRW-1:0];
    end
  end
endmodule

// File: rtl/ratio_search.sv
module ratio_search
  import ratio_search_pkg::*;
#(
  parameter int RW       = 32,
  parameter int NSRC     = 4,
  parameter int PRE_MAX  = 32,
  parameter int POST_MAX = 4,
  parameter int BAND_SRC = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [NSRC*RW-1:0]          src_rates,
  input  logic [RW-1:0]               target,
  output logic                        done,
  output logic [$clog2(NSRC)-1:0]     sel_src,
  output logic [$clog2(PRE_MAX)-1:0]  pre_code,
  output logic [$clog2(POST_MAX)-1:0] post_code,
  output logic [RW-1:0]               achieved,
  output logic                        err
);
  localparam int IW  = $clog2(NSRC);
  localparam int PCW = $clog2(PRE_MAX);
  localparam int OCW = $clog2(POST_MAX);
  localparam int PRW = PCW + 1;
  localparam int POW = OCW + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_s;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_s <= 2'b00;
    else        rst_s <= {rst_s[0], 1'b1};
  end
  assign rst_i = rst_s[1];

  srch_state_t state, state_n;
  logic [IW-1:0]      idx, idx_n, bi_q, bi_n;
  logic [NSRC*RW-1:0] rates_q, rates_n;
  logic [RW-1:0]      tgt_q, tgt_n, total_q, total_n, ba_q, ba_n;
  logic [PRW-1:0]     pre_q, pre_n;
  logic [POW-1:0]     post_q, post_n;
  logic [PCW-1:0]     bp_q, bp_n;
  logic [OCW-1:0]     bo_q, bo_n;
  logic               bv_q, bv_n, err_q, err_n;

  logic [RW-1:0]  cur_rate, clamp_t, div_den, quo, rem, prod;
  logic           div_go, div_done;
  logic [PRW-1:0] sp_pre;
  logic [POW-1:0] sp_post;

  assign cur_rate = rates_q[idx*RW +: RW];
  assign clamp_t  = (tgt_q > cur_rate) ? cur_rate : tgt_q;
  assign prod     = RW'(pre_q) * RW'(post_q);

  rs_ratio_split #(.W(RW), .PRE_MAX(PRE_MAX), .POST_MAX(POST_MAX)) u_split (
    .total(total_q), .banded(idx == IW'(BAND_SRC)),
    .pre_ratio(sp_pre), .post_ratio(sp_post)
  );

  rs_divider #(.W(RW)) u_div (
    .clk(clk), .rst_n(rst_i), .go(div_go), .num(cur_rate), .den(div_den),
    .done(div_done), .quo(quo), .rem(rem)
  );

  always_comb begin
    state_n = state; idx_n = idx; rates_n = rates_q; tgt_n = tgt_q;
    total_n = total_q; pre_n = pre_q; post_n = post_q;
    bv_n = bv_q; bi_n = bi_q; bp_n = bp_q; bo_n = bo_q; ba_n = ba_q;
    err_n = err_q; div_go = 1'b0; div_den = clamp_t;
    case (state)
      S_IDLE: if (start) begin
        rates_n = src_rates; tgt_n = target; idx_n = '0;
        bv_n = 1'b0; bi_n = '0; bp_n = '0; bo_n = '0; ba_n = '0;
        state_n = S_SETUP;
      end
      S_SETUP: begin
        if (tgt_q == '0) state_n = S_FIN;
        else if (cur_rate == '0) begin
          if (idx == IW'(NSRC-1)) state_n = S_FIN;
          else idx_n = idx + IW'(1);
        end else begin
          div_go = 1'b1; div_den = clamp_t; state_n = S_TOT;
        end
      end
      S_TOT: if (div_done) begin
        total_n = quo + RW'(rem != '0);
        state_n = S_SPLIT;
      end
      S_SPLIT: begin
        pre_n = sp_pre; post_n = sp_post;
        div_go = 1'b1; div_den = RW'(sp_pre) * RW'(sp_post);
        state_n = S_ACH;
      end
      S_ACH: if (div_done) begin
        if (quo <= tgt_q && (!bv_q || quo > ba_q)) begin
          bv_n = 1'b1; bi_n = idx; ba_n = quo;
          bp_n = PCW'(pre_q - PRW'(1)); bo_n = OCW'(post_q - POW'(1));
        end
        if (idx == IW'(NSRC-1)) state_n = S_FIN;
        else begin idx_n = idx + IW'(1); state_n = S_SETUP; end
      end
      S_FIN: state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
    if (state_n == S_FIN && state != S_FIN) err_n = !bv_n;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state <= S_IDLE; idx <= '0; rates_q <= '0; tgt_q <= '0; total_q <= '0;
      pre_q <= '0; post_q <= '0; bv_q <= 1'b0; bi_q <= '0; bp_q <= '0;
      bo_q <= '0; ba_q <= '0; err_q <= 1'b0;
    end else begin
      state <= state_n; idx <= idx_n; rates_q <= rates_n; tgt_q <= tgt_n;
      total_q <= total_n; pre_q <= pre_n; post_q <= post_n; bv_q <= bv_n;
      bi_q <= bi_n; bp_q <= bp_n; bo_q <= bo_n; ba_q <= ba_n; err_q <= err_n;
    end
  end

  assign done      = (state == S_FIN);
  assign sel_src   = bi_q;
  assign pre_code  = bp_q;
  assign post_code = bo_q;
  assign achieved  = ba_q;
  assign err       = err_q;

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_i)
    done |=> !done);
  // R9: captured request does not move while a search runs
  p_hold_request_r9: assert property (@(posedge clk) disable iff (!rst_i)
    (state != S_IDLE) |=> $stable(tgt_q));
  // R8: failed search reports zeros
  p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_i)
    (done && err) |-> (achieved == '0 && sel_src == '0 && pre_code == '0 && post_code == '0));
  // R7: a successful result never exceeds the request
  p_ach_bound_r7: assert property (@(posedge clk) disable iff (!rst_i)
    (done && !err) |-> (achieved <= tgt_q));
  // R3: unbanded sources never use the pre stage
  p_unbanded_pre_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (state == S_ACH && idx != IW'(BAND_SRC)) |-> (pre_q == PRW'(1)));
endmodule

// File: tb/tb_ratio_search.sv
module tb_ratio_search;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] src_rates = '0;
  logic [31:0]  target = '0;
  logic         done, err;
  logic [1:0]   sel_src, post_code;
  logic [4:0]   pre_code;
  logic [31:0]  achieved;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  ratio_search dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_rates(src_rates),
    .target(target), .done(done), .sel_src(sel_src), .pre_code(pre_code),
    .post_code(post_code), .achieved(achieved), .err(err)
  );

  longint mr[4];
  longint e_sel, e_pre, e_post, e_ach;
  bit     e_err;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference
  function automatic void model(input longint t);
    bit found = 0;
    longint best = 0;
    e_sel = 0; e_pre = 0; e_post = 0; e_ach = 0;
    for (int i = 0; i < 4; i++) begin
      longint c, tot, pre, post, a;
      if (t == 0) break;
      if (mr[i] == 0) continue;
      c   = (t > mr[i]) ? mr[i] : t;
      tot = (mr[i] + c - 1) / c;
      if (i != 3 || tot <= 4) begin pre = 1; post = (tot > 4) ? 4 : tot; end
      else if (tot < 32) begin pre = tot; post = 1; end
      else if (tot < 64) begin post = 2; pre = (tot + 1) / 2; end
      else if (tot < 96) begin post = 3; pre = (tot + 2) / 3; end
      else begin post = 4; pre = (tot + 3) / 4; if (pre > 32) pre = 32; end
      a = (mr[i] / pre) / post;
      if (a <= t && (!found || a > best)) begin
        found = 1; best = a;
        e_sel = i; e_pre = pre - 1; e_post = post - 1; e_ach = a;
      end
    end
    e_err = !found;
  endfunction

  task automatic run(input longint r0, r1, r2, r3, t, input bit poke, input string req);
    int cyc = 0;
    mr[0] = r0; mr[1] = r1; mr[2] = r2; mr[3] = r3;
    model(t);
    @(negedge clk);
    src_rates = {r3[31:0], r2[31:0], r1[31:0], r0[31:0]};
    target = t[31:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 2000) begin
      if (poke && cyc == 10) begin
        start = 1'b1; target = 32'd7; src_rates = {4{32'd999}};
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL R9 done timeout: actual 0 expected 1");
    end else begin
      chk(req, "err", err, e_err);
      chk(req, "sel_src", sel_src, e_sel);
      chk(req, "pre_code", pre_code, e_pre);
      chk(req, "post_code", post_code, e_post);
      chk(req, "achieved", achieved, e_ach);
      @(negedge clk);
      chk("R9", "done one cycle", done, 0);
    end
  endtask

  initial begin
    logic [31:0] x;
    x = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "done", done, 0);
    chk("R1", "err", err, 0);
    chk("R1", "sel_src", sel_src, 0);
    chk("R1", "pre_code", pre_code, 0);
    chk("R1", "post_code", post_code, 0);
    chk("R1", "achieved", achieved, 0);

    run(1000, 2000, 3000, 4000, 500, 0, "R7 tie");          // src0,1,3 all reach 500
    run(0, 0, 0, 700, 1000, 0, "R2 clamp");                 // clamp to 700
    run(0, 0, 0, 4000, 100, 0, "R5 band2");                 // total 40
    run(0, 0, 0, 8000, 100, 0, "R5 band3");                 // total 80
    run(0, 0, 0, 10000, 100, 0, "R5 band4");                // total 100
    run(300, 0, 0, 100000, 100, 0, "R5 saturate");          // src3 overshoots
    run(0, 0, 0, 1500, 100, 0, "R4 pre only");              // total 15
    run(0, 1001, 0, 0, 500, 0, "R2 ceil");                  // total 3
    run(0, 9000, 0, 0, 1000, 0, "R3 post sat");             // no qualifier
    run(0, 0, 0, 0, 500, 0, "R8 all zero");
    run(1000, 2000, 3000, 4000, 0, 0, "R8 zero target");
    run(1000, 1000, 1000, 1000, 1, 0, "R8 none fit");
    run(0, 0, 12345, 0, 4000, 0, "R6 floor");
    run(1000, 2000, 3000, 4000, 500, 1, "R9 busy start");
    for (int k = 0; k < 30; k++) begin
      longint rr[4];
      longint tt;
      for (int j = 0; j < 4; j++) begin
        x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
        rr[j] = (x[1:0] == 2'b00) ? 0 : longint'(x % 32'd250000);
      end
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      tt = longint'(x % 32'd6000);
      run(rr[0], rr[1], rr[2], rr[3], tt, 0, "R6 R7 mixed");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule